// File: doc/BRIEF.md
# Tag CAM with LRU Replacement

This block is a small fully associative tag store. Threads that are about to perform a read-modify-write on a shared memory location use it to find out whether an earlier thread already holds that location. A lookup presents a 32-bit key, and every entry is compared against it in the same cycle. On a hit the block returns the index of the matching entry and the 4 user-defined state bits that were stored with the tag. Software typically uses these bits to record which earlier thread owns the location, so that a later thread can take the data from that thread and skip a second memory fetch. On a miss the block returns the index of the least recently used entry, which is the slot the caller should reload.

A separate write port loads a tag and its state bits into an entry chosen by the caller. A clear mask invalidates any set of entries. The block holds only tags, state bits, valid flags and the replacement order. It holds no cached data and starts no memory access.

Top module: `tag_cam`

## Requirements
- R1: After reset, every entry is invalid, `res_vld` and `res_word` are 0, and the replacement order from oldest to newest is entry 0, entry 1, …, entry 15. A first lookup therefore misses with index 0.
- R2: `res_vld` is high exactly one clock after a cycle in which `lkp_en` was high, and low after a cycle in which it was low.
- R3: The result is packed as `res_word[8]` = hit, `res_word[7:4]` = state, `res_word[3:0]` = entry index. On a hit, the index is the matching entry and the state is the 4 bits stored in that entry.
- R4: On a miss, the hit bit is 0, the state field is 0, and the index is the least recently used entry.
- R5: A write to an entry makes that entry the most recently used. A lookup hit makes the matched entry the most recently used. A lookup miss leaves the order unchanged.
- R6: Setting bit i of `clr_mask` invalidates entry i. An invalid entry never matches, whatever tag it still holds.
- R7: When more than one valid entry holds the looked-up key, the lowest index is reported.
- R8: A lookup in the same cycle as a write sees the newly written entry. When a write and a hit happen in the same cycle, the write is applied to the order first, then the hit. The miss victim is taken after the write has been applied.
- R9: A write and a clear of the same entry in the same cycle leave the entry valid with the new contents. Clearing an entry does not change the replacement order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lkp_en | input | 1 | Start a lookup this cycle |
| lkp_key | input | 32 | Key to search for |
| wr_en | input | 1 | Load an entry this cycle |
| wr_idx | input | 4 | Entry to load |
| wr_key | input | 32 | Tag to store |
| wr_state | input | 4 | User-defined state bits to store |
| clr_mask | input | 16 | One bit per entry; a set bit invalidates that entry |
| res_vld | output | 1 | Lookup result is valid this cycle |
| res_word | output | 9 | {hit, state[3:0], index[3:0]}; holds its value while `res_vld` is low |

## Verification
The embedded assertions check the following on every cycle:
- the result valid timing;
- a zero state field on every miss;
- that a reported hit names a valid entry holding the key with the reported state;
- that cleared entries come out invalid;
- that a touched entry becomes the newest;
- that exactly one entry is oldest.

Some behaviours only the bench scenarios can show, because they depend on the history of earlier operations. These are whether the miss index is truly the least recently used entry, the lowest-index choice among duplicate tags, write-first resolution within a cycle, and a clear leaving the order untouched. The bench checks them against an independent list-based model of recency.

// File: rtl/tag_cam_pkg.sv
package tag_cam_pkg;
    localparam int DEF_ENTRIES = 16;
    localparam int DEF_KEY_W   = 32;
    localparam int DEF_STATE_W = 4;
endpackage

// File: rtl/tag_cam_match.sv
// Parallel tag compare with a lowest-index-wins priority encoder.
module tag_cam_match #(
    parameter int N     = 16,
    parameter int KEY_W = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][KEY_W-1:0] tags,
    input  logic [KEY_W-1:0]        key,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);
    logic [N-1:0] eq;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign eq[g] = valid[g] && (tags[g] == key);
        end
    endgenerate

    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tag_cam_lru.sv
// Recency tracker: one rank per entry, 0 = oldest, N-1 = newest.
module tag_cam_lru #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_en,     // first touch (write)
    input  logic [IDX_W-1:0] a_idx,
    input  logic             b_en,     // second touch (lookup hit)
    input  logic [IDX_W-1:0] b_idx,
    output logic [IDX_W-1:0] victim
);
    localparam logic [IDX_W-1:0] NEWEST = IDX_W'(N - 1);

    typedef struct packed {
        logic [N-1:0][IDX_W-1:0] rank;
    } lru_s;

    lru_s s_d, s_q;
    logic [N-1:0][IDX_W-1:0] rank_mid;
    logic [N-1:0]            oldest_vec;

    always_comb begin
        rank_mid = s_q.rank;
        if (a_en) begin
            for (int j = 0; j < N; j++) begin
                if (s_q.rank[j] > s_q.rank[a_idx]) rank_mid[j] = s_q.rank[j] - 1'b1;
            end
            rank_mid[a_idx] = NEWEST;
        end

        victim = '0;
        for (int j = 0; j < N; j++) begin
            if (rank_mid[j] == '0) victim = IDX_W'(j);
        end

        s_d.rank = rank_mid;
        if (b_en) begin
            for (int j = 0; j < N; j++) begin
                if (rank_mid[j] > rank_mid[b_idx]) s_d.rank[j] = rank_mid[j] - 1'b1;
            end
            s_d.rank[b_idx] = NEWEST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < N; j++) s_q.rank[j] <= IDX_W'(j);
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        for (int j = 0; j < N; j++) oldest_vec[j] = (s_q.rank[j] == '0);
    end

    // R5
    hit_touch_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_en |=> s_q.rank[$past(b_idx)] == NEWEST);

    // R5
    wr_touch_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && !b_en) |=> s_q.rank[$past(a_idx)] == NEWEST);

    // R4
    single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(oldest_vec));
endmodule

// File: rtl/tag_cam.sv
module tag_cam #(
    parameter int ENTRIES = tag_cam_pkg::DEF_ENTRIES,
    parameter int KEY_W   = tag_cam_pkg::DEF_KEY_W,
    parameter int STATE_W = tag_cam_pkg::DEF_STATE_W,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int RES_W  = 1 + STATE_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lkp_en,
    input  logic [KEY_W-1:0]   lkp_key,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [KEY_W-1:0]   wr_key,
    input  logic [STATE_W-1:0] wr_state,
    input  logic [ENTRIES-1:0] clr_mask,
    output logic               res_vld,
    output logic [RES_W-1:0]   res_word
);
    typedef struct packed {
        logic [ENTRIES-1:0]              valid;
        logic [ENTRIES-1:0][KEY_W-1:0]   tag;
        logic [ENTRIES-1:0][STATE_W-1:0] st;
        logic                            res_vld;
        logic [RES_W-1:0]                res;
    } cam_s;

    cam_s s_d, s_q;

    // Effective table for this cycle: clear first, then write (write-first view)
    logic [ENTRIES-1:0]              eff_valid;
    logic [ENTRIES-1:0][KEY_W-1:0]   eff_tag;
    logic [ENTRIES-1:0][STATE_W-1:0] eff_st;
    logic                            m_hit;
    logic [IDX_W-1:0]                m_idx;
    logic [IDX_W-1:0]                victim;
    logic [ENTRIES-1:0]              wr_hot;

    always_comb begin
        eff_valid = s_q.valid & ~clr_mask;
        eff_tag   = s_q.tag;
        eff_st    = s_q.st;
        wr_hot    = '0;
        if (wr_en) begin
            eff_valid[wr_idx] = 1'b1;
            eff_tag[wr_idx]   = wr_key;
            eff_st[wr_idx]    = wr_state;
            wr_hot[wr_idx]    = 1'b1;
        end
    end

    tag_cam_match #(.N(ENTRIES), .KEY_W(KEY_W)) u_match (
        .valid (eff_valid),
        .tags  (eff_tag),
        .key   (lkp_key),
        .hit   (m_hit),
        .idx   (m_idx)
    );

    tag_cam_lru #(.N(ENTRIES)) u_lru (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_en   (wr_en),
        .a_idx  (wr_idx),
        .b_en   (lkp_en && m_hit),
        .b_idx  (m_idx),
        .victim (victim)
    );

    always_comb begin
        s_d         = s_q;
        s_d.valid   = eff_valid;
        s_d.tag     = eff_tag;
        s_d.st      = eff_st;
        s_d.res_vld = lkp_en;
        if (lkp_en) begin
            if (m_hit) s_d.res = {1'b1, eff_st[m_idx], m_idx};
            else       s_d.res = {1'b0, {STATE_W{1'b0}}, victim};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign res_vld  = s_q.res_vld;
    assign res_word = s_q.res;

    logic               res_hit;
    logic [IDX_W-1:0]   res_idx;
    logic [STATE_W-1:0] res_st;
    assign res_hit = res_word[RES_W-1];
    assign res_idx = res_word[IDX_W-1:0];
    assign res_st  = res_word[IDX_W +: STATE_W];

    // R2
    res_follows_lkp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_en |=> res_vld);

    // R2
    no_spurious_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_en |=> !res_vld);

    // R4
    miss_state_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_hit) |-> (res_st == '0));

    // R3
    hit_entry_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_hit) |-> (s_q.valid[res_idx] && s_q.tag[res_idx] == $past(lkp_key)
                                  && s_q.st[res_idx] == res_st));

    // R6
    clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_mask) |=> ((s_q.valid & $past(clr_mask) & ~$past(wr_hot)) == '0));
endmodule

// File: tb/tag_cam_bench.sv
module tag_cam_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lkp_en;
    logic [31:0] lkp_key;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [31:0] wr_key;
    logic [3:0]  wr_state;
    logic [15:0] clr_mask;
    logic        res_vld;
    logic [8:0]  res_word;

    always #5 clk = ~clk;

    tag_cam u_tag_cam (
        .clk(clk), .rst_n(rst_n), .lkp_en(lkp_en), .lkp_key(lkp_key),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(wr_key), .wr_state(wr_state),
        .clr_mask(clr_mask), .res_vld(res_vld), .res_word(res_word)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        bit         vld;
        logic [8:0] word;
        string      req;
    } exp_t;
    exp_t sbq[$];

    // Reference model: list of entries from oldest to newest
    bit          m_valid[16];
    logic [31:0] m_tag[16];
    logic [3:0]  m_st[16];
    int          m_order[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [8:0] act, input logic [8:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic touch(input int e);
        for (int k = 0; k < m_order.size(); k++) begin
            if (m_order[k] == e) begin
                m_order.delete(k);
                break;
            end
        end
        m_order.push_back(e);
    endtask

    // Driver: called at a falling edge, drives one cycle, pushes the expectation
    task automatic step(input bit le, input logic [31:0] lk,
                        input bit we, input logic [3:0] wi, input logic [31:0] wk,
                        input logic [3:0] ws, input logic [15:0] cm, input string req);
        exp_t e;
        int   hi;
        lkp_en = le; lkp_key = lk;
        wr_en = we; wr_idx = wi; wr_key = wk; wr_state = ws; clr_mask = cm;
        for (int i = 0; i < 16; i++) if (cm[i]) m_valid[i] = 1'b0;
        if (we) begin
            m_valid[wi] = 1'b1; m_tag[wi] = wk; m_st[wi] = ws;
            touch(int'(wi));
        end
        e.vld = le; e.word = '0; e.req = req;
        if (le) begin
            hi = -1;
            for (int i = 15; i >= 0; i--) if (m_valid[i] && m_tag[i] == lk) hi = i;
            if (hi >= 0) begin
                e.word = {1'b1, m_st[hi], 4'(hi)};
                touch(hi);
            end else begin
                e.word = {1'b0, 4'h0, 4'(m_order[0])};
            end
        end
        sbq.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input string req);
        step(1'b0, '0, 1'b0, '0, '0, '0, '0, req);
    endtask

    task automatic lookup(input logic [31:0] k, input string req);
        step(1'b1, k, 1'b0, '0, '0, '0, '0, req);
    endtask

    task automatic write(input logic [3:0] i, input logic [31:0] k,
                         input logic [3:0] s, input string req);
        step(1'b0, '0, 1'b1, i, k, s, '0, req);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Monitor: samples just after each rising edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                e = sbq.pop_front();
                chk(res_vld == e.vld, e.req, "res_vld", {8'h0, res_vld}, {8'h0, e.vld});
                if (e.vld) chk(res_word == e.word, e.req, "res_word", res_word, e.word);
            end
        end
    end

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] lfsr;
        rst_n = 1'b0;
        lkp_en = 0; lkp_key = 0; wr_en = 0; wr_idx = 0; wr_key = 0; wr_state = 0; clr_mask = 0;
        for (int i = 0; i < 16; i++) begin
            m_valid[i] = 1'b0; m_tag[i] = '0; m_st[i] = '0; m_order.push_back(i);
        end
        repeat (3) @(negedge clk);
        // R1 reset outputs
        chk(res_vld == 1'b0, "R1", "reset res_vld", {8'h0, res_vld}, 9'h0);
        chk(res_word == 9'h0, "R1", "reset res_word", res_word, 9'h0);
        rst_n = 1'b1;
        @(negedge clk);

        lookup(32'hDEAD_BEEF, "R1");           // miss, victim 0
        lookup(32'h0000_0000, "R6");           // zero tag in invalid entry never matches
        idle("R2");
        for (int i = 0; i < 4; i++) write(4'(i), 32'h100 + i, 4'(i + 1), "R5");
        idle("R2");
        lookup(32'h102, "R3");                 // hit entry 2, state 3
        lookup(32'h100, "R3");                 // hit entry 0, state 1
        lookup(32'h5555, "R4");                // miss, victim 4
        write(4'd4, 32'h5555, 4'hA, "R5");
        lookup(32'h7777, "R4");                // victim 5
        // R5: order of first sixteen fills
        for (int i = 5; i < 16; i++) write(4'(i), 32'h200 + i, 4'(i), "R5");
        lookup(32'h9999, "R5");                // oldest now entry 1
        lookup(32'h101, "R5");                 // hit 1, becomes newest
        lookup(32'h9999, "R5");                // oldest now entry 3
        lookup(32'h9998, "R5");                // miss does not reorder: still 3
        // R7 duplicates
        write(4'd9, 32'h102, 4'h7, "R7");
        lookup(32'h102, "R7");                 // lowest index 2
        // R6 clear entry 2, duplicate in 9 now reported
        step(1'b0, '0, 1'b0, '0, '0, '0, 16'h0004, "R6");
        lookup(32'h102, "R6");
        // R8 write and lookup in same cycle
        step(1'b1, 32'hCAFE, 1'b1, 4'd7, 32'hCAFE, 4'h5, '0, "R8");
        step(1'b1, 32'hF00D, 1'b1, 4'd3, 32'hBEEF, 4'h6, '0, "R8"); // miss; victim after write
        // R9 clear and write the same entry together
        step(1'b1, 32'hABCD, 1'b1, 4'd11, 32'hABCD, 4'h9, 16'h0800, "R9");
        // R9 clear all: order unchanged, all miss
        step(1'b0, '0, 1'b0, '0, '0, '0, 16'hFFFF, "R9");
        lookup(32'hCAFE, "R9");
        lookup(32'hABCD, "R9");
        idle("R2");

        // Mixed pseudo-random traffic over a small tag set
        lfsr = 32'h1234_5678;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[0] | lfsr[1], {29'h0, lfsr[4:2]},
                 lfsr[5] & lfsr[6], lfsr[10:7], {29'h0, lfsr[13:11]}, lfsr[17:14],
                 (lfsr[20:18] == 3'b000) ? (16'h1 << lfsr[24:21]) : 16'h0, "R3");
        end
        idle("R2");
        idle("R2");
        @(negedge clk);
        summary();
    end
endmodule